// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It combines two sources of information. The first is a few low bits of the branch address. The second is the recent global record of branch outcomes. A shift register holds the directions of the most recent `HIST_BITS` resolved branches. Each address slot owns `2^HIST_BITS` saturating counters of `CTR_BITS` bits, and the history value picks one counter in that slot. The prediction is the top bit of the chosen counter.

A fetch stage presents a branch address on the lookup port and reads the direction in the same cycle, through combinational logic only. When a branch resolves, the execute stage presents its address and its real outcome on the training port. On the next clock edge the selected counter moves one step toward that outcome, and the history register takes in the outcome. The table holds `ENTRIES × 2^HIST_BITS × CTR_BITS` bits. With `HIST_BITS = 0` the block becomes a plain table of per-address counters.

Top module: `corr_branch_predictor`

## Requirements
- R1: After reset every counter holds the weakly-not-taken value 2^(CTR_BITS-1)-1 and the history is all zeros, so every lookup returns not-taken.
- R2: The lookup selects counter number `{pc[log2(ENTRIES)+1:2], history}`, with the history in the low bits. `pred_taken` is 1 exactly when that counter is at least 2^(CTR_BITS-1).
- R3: A training event with `upd_taken=1` raises the selected counter by one, and the counter holds at 2^CTR_BITS-1.
- R4: A training event with `upd_taken=0` lowers the selected counter by one, and the counter holds at 0.
- R5: Each training event shifts the history left by one position. The new outcome enters bit 0 (1 = taken), and the oldest bit is dropped.
- R6: A training event picks its counter using the history value from before that event's own shift.
- R7: When a lookup and a training event occur in the same cycle, the lookup sees the state from before the training. The training first shows at the ports in the following cycle.
- R8: Address bits [1:0] and all bits above bit log2(ENTRIES)+1 do not affect the choice of counter.
- R9: The same address combined with different history values reaches different counters, and those counters are trained independently.
- R10: While `upd_valid` is 0, no counter and no history bit changes, whatever values sit on `upd_pc` and `upd_taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Training event strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A lookup and a training event can fall in the same cycle, and they can even address the same counter. The bench provokes this constantly. Its random phase draws both addresses from a small shared pool, and its directed phase trains one address while looking up that same address. Each lookup is judged against a bench model whose state has not yet absorbed that cycle's training. The training is applied to the model only after the clock edge, which tests that reads come before writes and that the training uses the history from before its own shift.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

  // Saturating step of an unsigned counter bounded by [0, maxv].
  function automatic int unsigned sat_step(int unsigned v, bit up, int unsigned maxv);
    if (up) return (v >= maxv) ? maxv : v + 1;
    else    return (v == 0)    ? 0    : v - 1;
  endfunction

  // Joint counter number: address field above, history below.
  function automatic int unsigned join_index(int unsigned addr_field,
                                             int unsigned hist,
                                             int unsigned hbits);
    return (addr_field << hbits) | hist;
  endfunction

  // Push one outcome into a history of hbits bits, newest in bit 0.
  function automatic int unsigned hist_push(int unsigned h, bit t, int unsigned hbits);
    int unsigned mask;
    mask = (hbits == 0) ? 0 : ((32'd1 << hbits) - 1);
    return ((h << 1) | 32'(t)) & mask;
  endfunction

  // Counter value after reset: weakly not-taken.
  function automatic int unsigned weak_not_taken(int unsigned cbits);
    return (32'd1 << (cbits - 1)) - 1;
  endfunction

endpackage

// File: rtl/cbp_history.sv
module cbp_history #(
  parameter int HIST_BITS = 2,
  parameter int HW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          taken_in,
  output logic [HW-1:0] hist_q
);
  import cbp_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)
      hist_q <= '0;
    else if (shift_en)
      hist_q <= HW'(hist_push(32'(hist_q), taken_in, HIST_BITS));
  end

endmodule

// File: rtl/cbp_index.sv
module cbp_index #(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 4,
  parameter int HIST_BITS = 2,
  parameter int HW        = 2,
  parameter int CI_W      = 6
) (
  input  logic [PC_W-1:0] pc,
  input  logic [HW-1:0]   hist,
  output logic [CI_W-1:0] idx
);
  import cbp_pkg::*;

  logic [IDX_W-1:0] addr_field;
  assign addr_field = pc[IDX_W+1:2];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc[PC_W-1:IDX_W+2], pc[1:0]};

  generate
    if (HIST_BITS > 0) begin : g_hist
      assign idx = CI_W'(join_index(32'(addr_field), 32'(hist), HIST_BITS));
    end else begin : g_nohist
      logic unused_hist;
      assign unused_hist = ^hist;
      assign idx = CI_W'(addr_field);
    end
  endgenerate

endmodule

// File: rtl/cbp_counter_table.sv
module cbp_counter_table #(
  parameter int CTR_BITS = 2,
  parameter int CI_W     = 6,
  parameter int NUM_CTR  = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CI_W-1:0]             rd_idx,
  output logic [CTR_BITS-1:0]         rd_ctr,
  input  logic                        wr_en,
  input  logic [CI_W-1:0]             wr_idx,
  input  logic                        wr_taken,
  output logic [CTR_BITS-1:0]         wr_old,
  output logic [NUM_CTR*CTR_BITS-1:0] ctr_flat
);
  import cbp_pkg::*;

  localparam int unsigned CMAX  = (32'd1 << CTR_BITS) - 1;
  localparam int unsigned CINIT = weak_not_taken(CTR_BITS);

  logic [CTR_BITS-1:0] ctr [NUM_CTR];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CTR; gi++) begin : g_ctr
      always_ff @(posedge clk) begin
        if (!rst_n)
          ctr[gi] <= CTR_BITS'(CINIT);
        else if (wr_en && (wr_idx == CI_W'(gi)))
          ctr[gi] <= CTR_BITS'(sat_step(32'(ctr[gi]), wr_taken, CMAX));
      end
      assign ctr_flat[gi*CTR_BITS +: CTR_BITS] = ctr[gi];
    end
  endgenerate

  assign rd_ctr = ctr[rd_idx];
  assign wr_old = ctr[wr_idx];

endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor #(
  parameter int PC_W      = 32,
  parameter int ENTRIES   = 16,
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int HW      = (HIST_BITS > 0) ? HIST_BITS : 1;
  localparam int CI_W    = IDX_W + HIST_BITS;
  localparam int NUM_CTR = 1 << CI_W;

  // Named internal events, visible to the bound checker.
  logic [HW-1:0]               hist_q;
  logic [CI_W-1:0]             rd_idx;
  logic [CI_W-1:0]             wr_idx;
  logic [CTR_BITS-1:0]         rd_ctr;
  logic [CTR_BITS-1:0]         wr_old;
  logic [NUM_CTR*CTR_BITS-1:0] ctr_flat;

  cbp_history #(.HIST_BITS(HIST_BITS), .HW(HW)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (upd_valid),
    .taken_in (upd_taken),
    .hist_q   (hist_q)
  );

  cbp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_BITS(HIST_BITS), .HW(HW), .CI_W(CI_W)) u_rd_index (
    .pc   (pred_pc),
    .hist (hist_q),
    .idx  (rd_idx)
  );

  cbp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_BITS(HIST_BITS), .HW(HW), .CI_W(CI_W)) u_wr_index (
    .pc   (upd_pc),
    .hist (hist_q),
    .idx  (wr_idx)
  );

  cbp_counter_table #(.CTR_BITS(CTR_BITS), .CI_W(CI_W), .NUM_CTR(NUM_CTR)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rd_idx),
    .rd_ctr   (rd_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (wr_idx),
    .wr_taken (upd_taken),
    .wr_old   (wr_old),
    .ctr_flat (ctr_flat)
  );

  assign pred_taken = rd_ctr[CTR_BITS-1];

endmodule

// File: rtl/cbp_checker.sv
module cbp_checker #(
  parameter int CTR_BITS = 2,
  parameter int CI_W     = 6,
  parameter int NUM_CTR  = 64,
  parameter int HW       = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        upd_valid,
  input logic                        upd_taken,
  input logic [CI_W-1:0]             wr_idx,
  input logic [CTR_BITS-1:0]         wr_old,
  input logic [HW-1:0]               hist_q,
  input logic [NUM_CTR*CTR_BITS-1:0] ctr_flat
);
  localparam logic [CTR_BITS-1:0] CMAX = '1;

  logic                v_d;
  logic                t_d;
  logic [CI_W-1:0]     idx_d;
  logic [CTR_BITS-1:0] old_d;
  logic [CTR_BITS-1:0] slot_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_d   <= 1'b0;
      t_d   <= 1'b0;
      idx_d <= '0;
      old_d <= '0;
    end else begin
      v_d   <= upd_valid;
      t_d   <= upd_taken;
      idx_d <= wr_idx;
      old_d <= wr_old;
    end
  end

  assign slot_now = ctr_flat[idx_d*CTR_BITS +: CTR_BITS];

  assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (v_d && t_d && old_d != CMAX) |-> slot_now == old_d + 1'b1);
  assert_sat_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (v_d && t_d && old_d == CMAX) |-> slot_now == CMAX);
  assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (v_d && !t_d && old_d != '0) |-> slot_now == old_d - 1'b1);
  assert_sat_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (v_d && !t_d && old_d == '0) |-> slot_now == '0);
  assert_hist_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> hist_q[0] == $past(upd_taken) || HW == 1 && $past(hist_q) == '0 && hist_q == '0);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(hist_q) && $stable(ctr_flat));

endmodule

bind corr_branch_predictor cbp_checker #(
  .CTR_BITS(CTR_BITS), .CI_W(CI_W), .NUM_CTR(NUM_CTR), .HW(HW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_valid (upd_valid),
  .upd_taken (upd_taken),
  .wr_idx    (wr_idx),
  .wr_old    (wr_old),
  .hist_q    (hist_q),
  .ctr_flat  (ctr_flat)
);

// File: tb/corr_branch_predictor_bench.sv
module corr_branch_predictor_bench;
  localparam int PC_W = 32, ENTRIES = 16, HB = 2, CB = 2;
  localparam int NUM = ENTRIES << HB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] pred_pc = '0;
  logic [PC_W-1:0] upd_pc = '0;
  logic upd_valid = 1'b0;
  logic upd_taken = 1'b0;
  logic pred_taken;

  int checks = 0;
  int errors = 0;
  int ctr_m [NUM];
  int hist_m;

  always #4 clk = ~clk;

  corr_branch_predictor #(.PC_W(PC_W), .ENTRIES(ENTRIES), .HIST_BITS(HB), .CTR_BITS(CB)) u_corr_branch_predictor (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  function automatic int m_index(logic [PC_W-1:0] pc);
    return (int'((pc / 4) % ENTRIES) * (1 << HB)) + hist_m;
  endfunction

  function automatic bit m_pred(logic [PC_W-1:0] pc);
    return ctr_m[m_index(pc)] >= (1 << (CB - 1));
  endfunction

  task automatic m_train(logic [PC_W-1:0] pc, bit t);
    int i;
    i = m_index(pc);
    if (t && ctr_m[i] < (1 << CB) - 1) ctr_m[i]++;
    if (!t && ctr_m[i] > 0) ctr_m[i]--;
    hist_m = ((hist_m * 2) + int'(t)) % (1 << HB);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle: drive, judge lookup against pre-training model, then train model.
  task automatic step(logic [PC_W-1:0] ppc, bit uv, logic [PC_W-1:0] upc, bit ut, string req);
    bit e;
    @(negedge clk);
    pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
    #1;
    e = m_pred(ppc);
    check(pred_taken == e, req, int'(pred_taken), int'(e));
    @(posedge clk);
    if (uv) m_train(upc, ut);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    bit ref_p;
    logic [PC_W-1:0] pool [8];
    void'($urandom(32'd1234));
    for (int i = 0; i < NUM; i++) ctr_m[i] = (1 << (CB - 1)) - 1;
    hist_m = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: all lookups not-taken after reset
    for (int i = 0; i < ENTRIES; i++) step(32'(i * 4), 1'b0, '0, 1'b0, "R1");

    // R3, R7: train one address taken while looking it up in the same cycle
    for (int i = 0; i < 8; i++) step(32'h40, 1'b1, 32'h40, 1'b1, "R3/R7");
    step(32'h40, 1'b0, '0, 1'b0, "R3");

    // R8: aliasing addresses must agree with the base address
    @(negedge clk); pred_pc = 32'h40; upd_valid = 1'b0; #1; ref_p = pred_taken;
    pred_pc = 32'h43; #1;
    check(pred_taken == ref_p, "R8 low bits", int'(pred_taken), int'(ref_p));
    pred_pc = 32'h40 + 32'(ENTRIES * 4); #1;
    check(pred_taken == ref_p, "R8 high bits", int'(pred_taken), int'(ref_p));
    check(ref_p == 1'b1, "R2 trained taken", int'(ref_p), 1);

    // R4: drive another address to the floor
    for (int i = 0; i < 8; i++) step(32'h84, 1'b1, 32'h84, 1'b0, "R4");

    // R10: idle training port with noisy address and outcome
    for (int i = 0; i < 6; i++) step(32'h40, 1'b0, 32'h40, 1'b1, "R10");
    step(32'h80, 1'b0, 32'h80, 1'b0, "R10");

    // R6, R9: same address under alternating histories
    for (int i = 0; i < 12; i++) step(32'h48, 1'b1, 32'h48, i[0], "R6/R9");
    for (int i = 0; i < 4; i++) step(32'h48, 1'b1, 32'h10, i[1], "R9/R5");

    // R2, R5, R7: constrained random over a small address pool
    for (int i = 0; i < 8; i++) pool[i] = $urandom & 32'hFFFF_FFFF;
    for (int i = 0; i < 4000; i++) begin
      step(pool[$urandom % 8], ($urandom % 4) != 0, pool[$urandom % 8],
           ($urandom % 3) != 0, "R2/R5/R7");
    end

    finish_run();
  end
endmodule